// File: doc/BRIEF.md
# Rotating-Priority Shared-Bus Arbiter Node

This block is one node of a distributed arbiter for a bus shared by up to eight processors and one external host. Each processor carries its own identical copy. All copies watch the same shared request lines and apply the same registered decision on every clock. Every node therefore holds the same view of who the current bus master is, and no central grant wire is needed. A node learns that it may drive the bus from its local ownership output. The host learns that it owns the bus from the host grant.

Each processor drives one ordinary request line and one priority request line. The line at index i belongs to the processor whose static node ID is i. Normal handover is round-robin and moves upward from the current master. A host request takes the bus away from all processors. A priority request jumps over ordinary requesters. When the host lets go, mastership returns to the processor that held it before, and rotation carries on from that ID.

Top module: `rr_bus_arbiter_node`

## Requirements
- R1: While reset is asserted and after its release with no requests, master_id is 0 and host_grant is 0. own_bus is 1 only on the node whose node_id is 0.
- R2: own_bus is 1 exactly when host_grant is 0 and master_id equals node_id.
- R3: The master is handed over when it holds neither of its request bits and at least one bit of bus_req|prio_req is set. The new master is the first set candidate among master+1, master+2, and so on, wrapping modulo 8. The candidate set is prio_req if any prio_req bit is set, and bus_req|prio_req otherwise. All decisions take effect on the outputs one clock after the inputs are sampled.
- R4: A master whose bus_req bit is set keeps the bus while no prio_req bit is set.
- R5: If bus_req and prio_req are both all-zero, master_id does not change (the bus is parked).
- R6: host_req set makes host_grant 1 on the next clock, and host_grant stays 1 while host_req stays set. While host_grant is 1, no node asserts own_bus and master_id does not change.
- R7: When host_req clears, host_grant falls on the next clock. master_id is still the master from before the host took over, and the next arbitration rotates from that ID.
- R8: A prio_req bit from another node preempts a master that has no prio_req bit set. Among several prio_req bits, the rotating order from the current master decides. A master that has its own prio_req bit set keeps the bus.
- R9: Copies with different node IDs that see the same inputs report the same master_id and host_grant on every cycle. Exactly one node owns the bus, or the host does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all nodes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_id | input | 3 | Static unique ID of this node |
| bus_req | input | 8 | Ordinary bus requests, bit i from node i |
| prio_req | input | 8 | Priority bus requests, bit i from node i |
| host_req | input | 1 | External host bus request |
| own_bus | output | 1 | This node is the current bus master |
| master_id | output | 3 | ID of the current (or remembered) processor master |
| host_grant | output | 1 | The host owns the bus |

## Verification
The hardest case to reach is the host letting go while processors are preempting each other. The remembered master must come back, and the very next handover must rotate from that ID and not from wherever the requests last pointed. Directed steps build a known master first. They then raise the host request over a busy request pattern, drop it with no requests pending, and raise a priority request on the far side of the wrap. Random stimulus keeps the current master's request alive with high probability, so that holds, preemptions and host episodes overlap often.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ARB_ID_W = 3;

  typedef enum logic [2:0] {
    DEC_HOST     = 3'd0,
    DEC_RETURN   = 3'd1,
    DEC_HOLD     = 3'd2,
    DEC_PARK     = 3'd3,
    DEC_HANDOVER = 3'd4
  } arb_dec_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int ID_W = arb_pkg::ARB_ID_W,
  localparam int NODES = 1 << ID_W
) (
  input  logic [NODES-1:0] cand,
  input  logic [ID_W-1:0]  base,
  output logic [ID_W-1:0]  pick,
  output logic             any
);
  logic [ID_W-1:0] idx [NODES];

  genvar g;
  generate
    for (g = 1; g <= NODES; g++) begin : g_off
      assign idx[g-1] = ID_W'(base + ID_W'(g));
    end
  endgenerate

  always_comb begin
    pick = base;
    any  = 1'b0;
    for (int off = NODES; off >= 1; off--) begin
      if (cand[idx[off-1]]) begin
        pick = idx[off-1];
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    if (any) begin
      p_pick_is_candidate_r3: assert (cand[pick]);
    end
  end
endmodule

// File: rtl/arb_state.sv
module arb_state
  import arb_pkg::*;
#(
  parameter int ID_W = ARB_ID_W,
  localparam int NODES = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] bus_req,
  input  logic [NODES-1:0] prio_req,
  input  logic             host_req,
  output logic [ID_W-1:0]  master_q,
  output logic             host_q
);
  logic [NODES-1:0] eff_req;
  logic [NODES-1:0] cand;
  logic             prio_any;
  logic             holds;
  logic [ID_W-1:0]  pick;
  logic             cand_any;
  arb_dec_e         dec;
  logic [ID_W-1:0]  master_d;
  logic             master_en;
  logic             host_d;

  rr_pick #(.ID_W(ID_W)) u_pick (
    .cand (cand),
    .base (master_q),
    .pick (pick),
    .any  (cand_any)
  );

  always_comb begin
    eff_req  = bus_req | prio_req;
    prio_any = |prio_req;
    cand     = prio_any ? prio_req : eff_req;
    holds    = eff_req[master_q] && (prio_req[master_q] || !prio_any);
    if (host_req)       dec = DEC_HOST;
    else if (host_q)    dec = DEC_RETURN;
    else if (holds)     dec = DEC_HOLD;
    else if (!cand_any) dec = DEC_PARK;
    else                dec = DEC_HANDOVER;
    master_en = (dec == DEC_HANDOVER);
    master_d  = pick;
    host_d    = (dec == DEC_HOST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '0;
      host_q   <= 1'b0;
    end else begin
      host_q <= host_d;
      if (master_en) master_q <= master_d;
    end
  end

  p_host_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> host_q);
  p_host_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req || host_q) |=> $stable(master_q));
  p_host_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_q && !host_req) |=> !host_q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_req && !host_q && bus_req[master_q] && prio_req == '0) |=> $stable(master_q));
  p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_req && (bus_req | prio_req) == '0) |=> $stable(master_q));
  p_handover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_req && !host_q && !bus_req[master_q] && !prio_req[master_q]
     && (bus_req | prio_req) != '0) |=> (master_q != $past(master_q)));
endmodule

// File: rtl/rr_bus_arbiter_node.sv
module rr_bus_arbiter_node #(
  parameter int ID_W = arb_pkg::ARB_ID_W,
  localparam int NODES = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  node_id,
  input  logic [NODES-1:0] bus_req,
  input  logic [NODES-1:0] prio_req,
  input  logic             host_req,
  output logic             own_bus,
  output logic [ID_W-1:0]  master_id,
  output logic             host_grant
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  arb_state #(.ID_W(ID_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_req  (bus_req),
    .prio_req (prio_req),
    .host_req (host_req),
    .master_q (master_id),
    .host_q   (host_grant)
  );

  assign own_bus = !host_grant && (master_id == node_id);

  p_owner_excl_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    own_bus |-> !host_grant);
  p_owner_match_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!host_grant && master_id == node_id) |-> own_bus);
endmodule

// File: tb/test_rr_bus_arbiter_node.sv
module test_rr_bus_arbiter_node;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] bus_req = '0;
  logic [N-1:0] prio_req = '0;
  logic         host_req = 1'b0;
  logic         own_w [N];
  logic [2:0]   mid_w [N];
  logic         hg_w  [N];

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_m = 3'd0;
  logic       exp_h = 1'b0;

  always #4 clk = ~clk;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_node
      rr_bus_arbiter_node i_rr_bus_arbiter_node (
        .clk        (clk),
        .rst_n      (rst_n),
        .node_id    (3'(g)),
        .bus_req    (bus_req),
        .prio_req   (prio_req),
        .host_req   (host_req),
        .own_bus    (own_w[g]),
        .master_id  (mid_w[g]),
        .host_grant (hg_w[g])
      );
    end
  endgenerate

  function automatic logic [2:0] first_from(logic [2:0] m, logic [N-1:0] c);
    logic [2:0] r = m;
    for (int off = 1; off <= N; off++) begin
      if (c[3'((int'(m) + off) % N)]) return 3'((int'(m) + off) % N);
    end
    return r;
  endfunction

  task automatic model_step(logic [N-1:0] b, logic [N-1:0] p, logic h);
    logic [N-1:0] e = b | p;
    logic [N-1:0] c = (p != 0) ? p : e;
    if (h) exp_h = 1'b1;
    else if (exp_h) exp_h = 1'b0;
    else if (e[exp_m] && (p[exp_m] || p == 0)) exp_m = exp_m;
    else if (c != 0) exp_m = first_from(exp_m, c);
  endtask

  task automatic check_all(string req);
    int owners;
    owners = 0;
    for (int k = 0; k < N; k++) begin
      checks++;
      if (mid_w[k] !== exp_m || hg_w[k] !== exp_h) begin
        fails++;
        $display("FAIL %s node %0d: master=%0d host=%0b expected master=%0d host=%0b",
                 req, k, mid_w[k], hg_w[k], exp_m, exp_h);
      end
      checks++;
      if (own_w[k] !== (!exp_h && exp_m == 3'(k))) begin
        fails++;
        $display("FAIL R2 %s node %0d: own_bus=%0b expected %0b",
                 req, k, own_w[k], (!exp_h && exp_m == 3'(k)));
      end
      if (own_w[k] === 1'b1) owners++;
    end
    checks++;
    if (owners + (hg_w[0] === 1'b1 ? 1 : 0) != 1) begin
      fails++;
      $display("FAIL R9 %s: owners=%0d host=%0b expected exactly one", req, owners, hg_w[0]);
    end
  endtask

  task automatic cycle(logic [N-1:0] b, logic [N-1:0] p, logic h, string req);
    bus_req = b; prio_req = p; host_req = h;
    model_step(b, p, h);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] b, p;
    logic h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    for (int i = 0; i < 3; i++) cycle(8'b0000_0001, 8'h00, 1'b0, "R4 hold");
    cycle(8'b0001_0100, 8'h00, 1'b0, "R3 to 2");
    cycle(8'b0001_0000, 8'h00, 1'b0, "R3 to 4");
    cycle(8'b0000_0110, 8'h00, 1'b0, "R3 wrap to 1");
    for (int i = 0; i < 3; i++) cycle(8'h00, 8'h00, 1'b0, "R5 park");
    cycle(8'b0000_1000, 8'h00, 1'b0, "R3 to 3");
    cycle(8'b1010_1000, 8'h00, 1'b1, "R6 host take");
    cycle(8'b1111_0000, 8'h00, 1'b1, "R6 host hold");
    cycle(8'h00, 8'h00, 1'b0, "R7 host release");
    cycle(8'b0100_0001, 8'h00, 1'b0, "R7 rotate from 3");
    cycle(8'b0100_0000, 8'b0000_0110, 1'b0, "R8 preempt by 1");
    cycle(8'h00, 8'b1000_0010, 1'b0, "R8 master prio holds");
    cycle(8'h00, 8'b1001_0000, 1'b0, "R8 rotation among prio");

    for (int i = 0; i < 4000; i++) begin
      b = 8'($urandom);
      if ($urandom_range(0, 9) < 8) b[exp_m] = 1'b1;
      p = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00;
      h = ($urandom_range(0, 19) == 0) || (exp_h && $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) begin b = '0; p = '0; end
      cycle(b, p, h, "R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule